// File: doc/BRIEF.md
# Register Stack Push/Pop Sequencer

This block walks a register list through a series of single-word memory accesses to save registers onto a full-descending stack, or to restore them from it. A request carries an 8-bit register list, a flag that adds one extra slot, a direction, and the current stack pointer. On a save, the extra slot holds the link register. On a restore, it loads the program counter. The block reads register values from the register file through a select port. It writes restored values back through a write port. It returns the new stack pointer in the cycle that it signals completion.

The lowest address is worked out in the cycle of the request. A population count over the list, plus the extra flag, gives the number of words moved. Registers then move in ascending index order at ascending word addresses. The extra slot always comes last, at the highest address. Memory accepts an access in any cycle in which the ready input is high, and the block holds the access until then. The register file and the memory sit outside the block.

Top module: `stk_seq`

## Requirements
- R1: On a save (`pop_mode`=0), the first access goes to `sp_in` minus 4 times (number of ones in `reg_list` plus `extra_en`).
- R2: On a restore (`pop_mode`=1), the first access goes to `sp_in` itself.
- R3: Each access is completed by `mem_ready`=1 while `mem_req`=1. The number of accesses equals the word count. Each completed access moves the address up by 4. While `mem_ready` is low, the address and tag hold.
- R4: `mem_seq` is 0 (nonsequential) on the first access of a request and 1 (sequential) on every later access of it.
- R5: A save drives `mem_we`=1. Listed registers are selected through `rd_sel` in ascending index order, and `mem_wdata` carries each one. When `extra_en` is set, the link register (`rd_link`=1) is written last, at the highest address.
- R6: A restore writes each listed register through `rf_we`/`rf_idx`/`rf_wdata`, in ascending index order, in the cycle its read completes. When `extra_en` is set, the last read drives `pc_load` instead.
- R7: A restore raises `done` two cycles after its last completed read, which leaves one idle cycle between them.
- R8: In the `done` cycle, `sp_we`=1 and `sp_wdata` carries the final stack pointer: `sp_in` minus the byte total after a save, or `sp_in` plus the byte total after a restore. A save raises `done` one cycle after its last completed write.
- R9: After a save that moved at least one word, `fetch_nonseq` is 1 in the `done` cycle. After a restore, it is 0.
- R10: With an empty list and `extra_en`=0, no access is made and `sp_we` stays 0. `done` rises in the cycle after the request.
- R11: The value on `pc_value` always has bit 0 cleared, even when the word read has bit 0 set.
- R12: `start` is ignored while `busy` is 1, and the running request completes unchanged.
- R13: While `rst_n` is low, and right after it goes low, `busy`, `done`, `mem_req`, `rf_we`, `pc_load` and `sp_we` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request strobe, taken only when idle |
| pop_mode | input | 1 | 1 = restore from stack, 0 = save to stack |
| reg_list | input | NREG | Registers to move, bit i = register i |
| extra_en | input | 1 | Adds the link (save) or program-counter (restore) slot |
| sp_in | input | DW | Stack pointer at request time |
| mem_ready | input | 1 | Memory accepts or completes the current access |
| mem_rdata | input | DW | Read data for the current access |
| rd_data | input | DW | Register file value for `rd_sel` / `rd_link` |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Access request |
| mem_we | output | 1 | 1 = write access |
| mem_seq | output | 1 | 1 = sequential, 0 = nonsequential |
| mem_addr | output | DW | Word address of the access |
| mem_wdata | output | DW | Write data |
| rd_sel | output | log2(NREG) | Register index to read |
| rd_link | output | 1 | Read the link register instead of `rd_sel` |
| rf_we | output | 1 | Register file write strobe |
| rf_idx | output | log2(NREG) | Register index to write |
| rf_wdata | output | DW | Register write data |
| pc_load | output | 1 | Program-counter load strobe |
| pc_value | output | DW | Program-counter value, bit 0 clear |
| sp_we | output | 1 | Stack pointer update strobe |
| sp_wdata | output | DW | New stack pointer |
| fetch_nonseq | output | 1 | Next instruction fetch is to be nonsequential |

## Verification
The hardest case to reach from the ports is a second `start` that arrives while a long, stalled request is running. If the block took it, the register mask and the address would be overwritten halfway through the list. The stimulus runs a full restore with the extra slot and alternating ready. Two cycles in, it pulses `start` with a different direction, list and pointer, then checks every access and the final pointer against the first request. A reset asserted partway through a stalled save covers the matching abort path.

// File: rtl/stk_pkg.sv
// Shared definitions for the stack push/pop sequencer.
// Assumes word-sized stack slots of four bytes.
package stk_pkg;
    localparam int WORD_BYTES = 4;
    localparam int WORD_SHIFT = 2;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_XFER = 2'd1,
        ST_GAP  = 2'd2,
        ST_DONE = 2'd3
    } seq_state_e;
endpackage

// File: rtl/stk_popcount.sv
// Word counter: number of set bits in a list plus one optional extra slot.
// Purely combinational, one adder stage per list bit; CW must hold N+1.
module stk_popcount #(
    parameter int N  = 8,
    parameter int CW = 4
) (
    input  logic [N-1:0]  bits,
    input  logic          extra,
    output logic [CW-1:0] total
);
    logic [CW-1:0] partial [N+1];

    // Seed the running sum with the extra slot.
    assign partial[0] = CW'(extra);

    generate
        for (genvar i = 0; i < N; i++) begin : g_acc
            // Add one list bit to the running sum.
            assign partial[i+1] = partial[i] + CW'(bits[i]);
        end
    endgenerate

    assign total = partial[N];
endmodule

// File: rtl/stk_pick.sv
// Lowest-set-bit picker: gives the index of the lowest set bit of a mask,
// whether any bit is set, and the mask with that bit removed.
// Combinational; idx is zero when the mask is empty.
module stk_pick #(
    parameter int N  = 8,
    parameter int IW = 3
) (
    input  logic [N-1:0]  mask,
    output logic          any,
    output logic [IW-1:0] idx,
    output logic [N-1:0]  rest
);
    logic [N-1:0]  lowest;
    logic [IW-1:0] enc [N+1];

    // Isolate the lowest set bit as a one-hot vector.
    assign lowest = mask & (~mask + {{(N-1){1'b0}}, 1'b1});
    assign rest   = mask & ~lowest;
    assign any    = |mask;
    assign enc[0] = '0;

    generate
        for (genvar i = 0; i < N; i++) begin : g_enc
            // Fold the one-hot position into a binary index.
            assign enc[i+1] = enc[i] | (lowest[i] ? IW'(i) : '0);
        end
    endgenerate

    assign idx = enc[N];
endmodule

// File: rtl/stk_span.sv
// Stack span arithmetic: from the stack pointer and the word count it gives
// the lowest slot address and the final stack pointer for either direction.
// Assumes a full-descending stack with four-byte slots.
module stk_span #(
    parameter int DW = 32,
    parameter int CW = 4
) (
    input  logic [DW-1:0] sp,
    input  logic [CW-1:0] count,
    input  logic          pop,
    output logic [DW-1:0] base,
    output logic [DW-1:0] sp_next
);
    logic [DW-1:0] span;

    // Byte total of the transfer.
    assign span    = DW'(count) << stk_pkg::WORD_SHIFT;
    assign base    = pop ? sp : sp - span;
    assign sp_next = pop ? sp + span : sp - span;
endmodule

// File: rtl/stk_seq.sv
// Stack push/pop sequencer top.
// Takes one request while idle, then issues one word access per list bit in
// ascending order, plus an optional last slot (link on save, PC on restore).
// Assumes the register file answers rd_sel/rd_link combinationally and the
// memory completes an access in any cycle with mem_req and mem_ready high.
module stk_seq #(
    parameter int NREG = 8,
    parameter int DW   = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic                     pop_mode,
    input  logic [NREG-1:0]          reg_list,
    input  logic                     extra_en,
    input  logic [DW-1:0]            sp_in,
    input  logic                     mem_ready,
    input  logic [DW-1:0]            mem_rdata,
    input  logic [DW-1:0]            rd_data,
    output logic                     busy,
    output logic                     done,
    output logic                     mem_req,
    output logic                     mem_we,
    output logic                     mem_seq,
    output logic [DW-1:0]            mem_addr,
    output logic [DW-1:0]            mem_wdata,
    output logic [$clog2(NREG)-1:0]  rd_sel,
    output logic                     rd_link,
    output logic                     rf_we,
    output logic [$clog2(NREG)-1:0]  rf_idx,
    output logic [DW-1:0]            rf_wdata,
    output logic                     pc_load,
    output logic [DW-1:0]            pc_value,
    output logic                     sp_we,
    output logic [DW-1:0]            sp_wdata,
    output logic                     fetch_nonseq
);
    import stk_pkg::*;

    localparam int IW = $clog2(NREG);
    localparam int CW = $clog2(NREG + 2);

    seq_state_e      state_q;
    logic [NREG-1:0] mask_q;
    logic            extra_q;
    logic            pop_q;
    logic            first_q;
    logic [CW-1:0]   cnt_q;
    logic [DW-1:0]   addr_q;
    logic [DW-1:0]   spnew_q;

    logic [CW-1:0]   req_cnt;
    logic [DW-1:0]   req_base;
    logic [DW-1:0]   req_spnew;
    logic            mask_any;
    logic [IW-1:0]   cur_idx;
    logic [NREG-1:0] mask_rest;
    logic            in_xfer;
    logic            link_slot;
    logic            last_xfer;
    logic            handshake;

    stk_popcount #(.N(NREG), .CW(CW)) u_cnt (
        .bits  (reg_list),
        .extra (extra_en),
        .total (req_cnt)
    );

    stk_span #(.DW(DW), .CW(CW)) u_span (
        .sp      (sp_in),
        .count   (req_cnt),
        .pop     (pop_mode),
        .base    (req_base),
        .sp_next (req_spnew)
    );

    stk_pick #(.N(NREG), .IW(IW)) u_pick (
        .mask (mask_q),
        .any  (mask_any),
        .idx  (cur_idx),
        .rest (mask_rest)
    );

    // Decode the current slot and whether it ends the sequence.
    always_comb begin
        in_xfer   = (state_q == ST_XFER);
        link_slot = !mask_any;
        handshake = in_xfer && mem_ready;
        last_xfer = link_slot || ((mask_rest == '0) && !extra_q);
    end

    // Sequencer state, list bookkeeping and address stepping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            mask_q  <= '0;
            extra_q <= 1'b0;
            pop_q   <= 1'b0;
            first_q <= 1'b0;
            cnt_q   <= '0;
            addr_q  <= '0;
            spnew_q <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        mask_q  <= reg_list;
                        extra_q <= extra_en;
                        pop_q   <= pop_mode;
                        first_q <= 1'b1;
                        cnt_q   <= req_cnt;
                        addr_q  <= req_base;
                        spnew_q <= req_spnew;
                        state_q <= (req_cnt == '0) ? ST_DONE : ST_XFER;
                    end
                end
                ST_XFER: begin
                    if (handshake) begin
                        first_q <= 1'b0;
                        addr_q  <= addr_q + DW'(WORD_BYTES);
                        if (link_slot) begin
                            extra_q <= 1'b0;
                        end else begin
                            mask_q <= mask_rest;
                        end
                        if (last_xfer) begin
                            state_q <= pop_q ? ST_GAP : ST_DONE;
                        end
                    end
                end
                ST_GAP:  state_q <= ST_DONE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Memory side of the current access.
    always_comb begin
        mem_req   = in_xfer;
        mem_we    = in_xfer && !pop_q;
        mem_seq   = in_xfer && !first_q;
        mem_addr  = addr_q;
        mem_wdata = rd_data;
        rd_sel    = cur_idx;
        rd_link   = in_xfer && link_slot;
    end

    // Register file and program-counter writes on a completed restore read.
    always_comb begin
        rf_we    = handshake && pop_q && !link_slot;
        rf_idx   = cur_idx;
        rf_wdata = mem_rdata;
        pc_load  = handshake && pop_q && link_slot;
        pc_value = {mem_rdata[DW-1:1], 1'b0};
    end

    // Completion strobes and stack pointer update.
    always_comb begin
        busy         = (state_q != ST_IDLE);
        done         = (state_q == ST_DONE);
        sp_we        = done && (cnt_q != '0);
        sp_wdata     = spnew_q;
        fetch_nonseq = done && !pop_q && (cnt_q != '0);
    end
endmodule

// File: rtl/stk_seq_chk.sv
// Protocol checker for the stack sequencer, bound to every stk_seq instance.
// Observes ports only; assumes the synchronous active-low reset.
module stk_seq_chk #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mem_req,
    input logic          mem_we,
    input logic          mem_seq,
    input logic [DW-1:0] mem_addr,
    input logic          mem_ready,
    input logic          rf_we,
    input logic          pc_load,
    input logic          pc_lsb,
    input logic          sp_we,
    input logic          done
);
    // First access of a request is nonsequential.
    p_first_nonseq_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req) |-> !mem_seq);

    // Accesses after a completed one are sequential.
    p_later_seq_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ready) |=> (!mem_req || mem_seq));

    // Address steps by one word per completed access.
    p_addr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ready) |=> (!mem_req || (mem_addr == $past(mem_addr) + DW'(4))));

    // A stalled access holds.
    p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_seq)));

    // Saves never write the register file.
    p_save_no_rf_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> !(rf_we || pc_load));

    // At most one of the write strobes per cycle.
    p_one_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rf_we, pc_load, sp_we}));

    // Restore leaves an idle cycle before completion.
    p_restore_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(mem_req) && !$past(mem_we)) |-> !done);

    // Save completes right after its last write.
    p_save_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(mem_req) && $past(mem_we)) |-> done);

    // Stack pointer is written only with completion.
    p_sp_with_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sp_we |-> done);

    // Loaded program counter is halfword-even.
    p_pc_even_r11: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |-> !pc_lsb);
endmodule

bind stk_seq stk_seq_chk #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_seq   (mem_seq),
    .mem_addr  (mem_addr),
    .mem_ready (mem_ready),
    .rf_we     (rf_we),
    .pc_load   (pc_load),
    .pc_lsb    (pc_value[0]),
    .sp_we     (sp_we),
    .done      (done)
);

// File: tb/sim_stk_seq.sv
`timescale 1ns/1ps
// Self-checking bench for stk_seq: vector table, then directed corner cases.
module sim_stk_seq;
    localparam int NREG = 8;
    localparam int DW   = 32;
    localparam logic [31:0] LR_VAL = 32'hCAFE_0003;

    typedef struct packed {
        logic        pop;
        logic [7:0]  list;
        logic        extra;
        logic [31:0] sp;
        logic        stall;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{1'b0, 8'b1011_0001, 1'b1, 32'h0000_1000, 1'b0},
        '{1'b1, 8'b1011_0001, 1'b1, 32'h0000_0FEC, 1'b0},
        '{1'b0, 8'hFF,        1'b0, 32'h0000_2000, 1'b1},
        '{1'b1, 8'hFF,        1'b1, 32'h0000_3000, 1'b1},
        '{1'b0, 8'h01,        1'b0, 32'h0000_0100, 1'b0},
        '{1'b1, 8'h80,        1'b0, 32'h0000_0200, 1'b1},
        '{1'b0, 8'h00,        1'b1, 32'h0000_0400, 1'b0},
        '{1'b1, 8'h00,        1'b1, 32'h0000_0500, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        pop_mode = 1'b0;
    logic [7:0]  reg_list = '0;
    logic        extra_en = 1'b0;
    logic [31:0] sp_in = '0;
    logic        mem_ready = 1'b0;
    logic        stall_mode = 1'b0;
    logic [31:0] mem_rdata, rd_data;
    logic        busy, done, mem_req, mem_we, mem_seq, rd_link, rf_we, pc_load, sp_we, fetch_nonseq;
    logic [31:0] mem_addr, mem_wdata, rf_wdata, pc_value, sp_wdata;
    logic [2:0]  rd_sel, rf_idx;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    function automatic logic [31:0] reg_val(input int i);
        return 32'h1111_1111 * (i + 1);
    endfunction

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return a * 3 + 32'h1000_0001;
    endfunction

    assign rd_data   = rd_link ? LR_VAL : reg_val(int'(rd_sel));
    assign mem_rdata = mem_word(mem_addr);

    stk_seq #(.NREG(NREG), .DW(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .pop_mode(pop_mode),
        .reg_list(reg_list), .extra_en(extra_en), .sp_in(sp_in),
        .mem_ready(mem_ready), .mem_rdata(mem_rdata), .rd_data(rd_data),
        .busy(busy), .done(done), .mem_req(mem_req), .mem_we(mem_we),
        .mem_seq(mem_seq), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .rd_sel(rd_sel), .rd_link(rd_link), .rf_we(rf_we), .rf_idx(rf_idx),
        .rf_wdata(rf_wdata), .pc_load(pc_load), .pc_value(pc_value),
        .sp_we(sp_we), .sp_wdata(sp_wdata), .fetch_nonseq(fetch_nonseq)
    );

    // Memory ready pattern: always ready, or alternating when stalling.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            mem_ready = stall_mode ? ~mem_ready : 1'b1;
        end
    end

    // Port monitor, sampling away from the active edge.
    int          cyc = 0, nlog = 0, start_cyc = 0, last_hs = 0, done_cyc = 0, any_req = 0;
    bit          done_seen = 0;
    logic        d_spwe, d_fnz;
    logic [31:0] d_spv;
    logic [31:0] log_addr [16];
    logic [31:0] log_wd [16];
    logic [31:0] log_rfd [16];
    logic [31:0] log_pcv [16];
    logic [2:0]  log_rfidx [16];
    logic        log_seq [16];
    logic        log_we [16];
    logic        log_rfwe [16];
    logic        log_pcld [16];
    logic        log_link [16];

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (start && !busy && rst_n) begin
            nlog = 0; start_cyc = cyc; done_seen = 0; any_req = 0;
        end
        if (mem_req) any_req = any_req + 1;
        if (mem_req && mem_ready && nlog < 16) begin
            log_addr[nlog] = mem_addr;   log_seq[nlog] = mem_seq;
            log_we[nlog]   = mem_we;     log_wd[nlog]  = mem_wdata;
            log_link[nlog] = rd_link;    log_rfwe[nlog] = rf_we;
            log_rfidx[nlog] = rf_idx;    log_rfd[nlog] = rf_wdata;
            log_pcld[nlog] = pc_load;    log_pcv[nlog] = pc_value;
            last_hs = cyc;
            nlog = nlog + 1;
        end
        if (done) begin
            done_seen = 1; done_cyc = cyc;
            d_spwe = sp_we; d_spv = sp_wdata; d_fnz = fetch_nonseq;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Issue one request, optionally with an extra start pulse while busy, then check it.
    task automatic run_op(input vec_t v, input bit mid_start);
        int n, base, exp_idx [16];
        int k;
        logic [31:0] span, exp_sp, a_bad, e_bad;
        bit ok;
        stall_mode = v.stall;
        @(posedge clk); #2;
        start = 1'b1; pop_mode = v.pop; reg_list = v.list; extra_en = v.extra; sp_in = v.sp;
        @(posedge clk); #2;
        start = 1'b0;
        if (mid_start) begin
            @(posedge clk); #2;
            start = 1'b1; pop_mode = ~v.pop; reg_list = 8'h0F; extra_en = 1'b0; sp_in = 32'hDEAD_0000;
            @(posedge clk); #2;
            start = 1'b0;
        end
        for (int t = 0; t < 400 && !done_seen; t++) @(posedge clk);
        @(posedge clk); #2;

        n = $countones(v.list) + int'(v.extra);
        span = 32'(n * 4);
        base = v.pop ? int'(v.sp) : int'(v.sp - span);
        exp_sp = v.pop ? v.sp + span : v.sp - span;
        k = 0;
        for (int i = 0; i < 8; i++) if (v.list[i]) begin exp_idx[k] = i; k = k + 1; end
        if (v.extra) exp_idx[k] = 8;

        chk(nlog == n, "R3 access count", 32'(nlog), 32'(n));
        if (n > 0)
            chk(log_addr[0] == 32'(base), v.pop ? "R2 restore start address" : "R1 save start address",
                log_addr[0], 32'(base));

        ok = 1; a_bad = 0; e_bad = 0;
        for (int j = 0; j < nlog && j < n; j++)
            if (ok && log_addr[j] != 32'(base + 4 * j)) begin ok = 0; a_bad = log_addr[j]; e_bad = 32'(base + 4 * j); end
        chk(ok, "R3 ascending addresses", a_bad, e_bad);

        ok = 1; a_bad = 0; e_bad = 0;
        for (int j = 0; j < nlog && j < n; j++)
            if (ok && log_seq[j] != (j > 0)) begin ok = 0; a_bad = 32'(log_seq[j]); e_bad = 32'(j > 0); end
        chk(ok, "R4 sequential tags", a_bad, e_bad);

        ok = 1; a_bad = 0; e_bad = 0;
        for (int j = 0; j < nlog && j < n; j++) begin
            logic [31:0] ev;
            if (!v.pop) begin
                ev = (exp_idx[j] == 8) ? LR_VAL : reg_val(exp_idx[j]);
                if (ok && (!log_we[j] || log_wd[j] != ev || log_link[j] != (exp_idx[j] == 8))) begin
                    ok = 0; a_bad = log_wd[j]; e_bad = ev;
                end
            end else if (exp_idx[j] == 8) begin
                ev = mem_word(log_addr[j]) & ~32'h1;
                if (ok && (!log_pcld[j] || log_rfwe[j] || log_pcv[j] != ev)) begin
                    ok = 0; a_bad = log_pcv[j]; e_bad = ev;
                end
            end else begin
                ev = mem_word(log_addr[j]);
                if (ok && (log_we[j] || !log_rfwe[j] || log_pcld[j] || int'(log_rfidx[j]) != exp_idx[j] || log_rfd[j] != ev)) begin
                    ok = 0; a_bad = {log_rfd[j][31:4], 1'b0, log_rfidx[j]}; e_bad = {ev[31:4], 1'b0, 3'(exp_idx[j])};
                end
            end
        end
        chk(ok, v.pop ? "R6 restore writes in order, PC last" : "R5 save data in order, link last", a_bad, e_bad);

        if (v.pop && v.extra && nlog == n && n > 0)
            chk(log_pcv[n-1][0] == 1'b0 && mem_word(log_addr[n-1])[0] == 1'b1, "R11 PC bit 0 cleared",
                log_pcv[n-1], mem_word(log_addr[n-1]) & ~32'h1);

        if (n == 0) begin
            chk(done_seen && done_cyc == start_cyc + 1, "R10 empty done timing", 32'(done_cyc), 32'(start_cyc + 1));
            chk(any_req == 0 && d_spwe == 1'b0, "R10 empty no access, SP kept", 32'(any_req), 32'h0);
        end else begin
            if (v.pop)
                chk(done_seen && done_cyc == last_hs + 2, "R7 restore idle cycle", 32'(done_cyc), 32'(last_hs + 2));
            else
                chk(done_seen && done_cyc == last_hs + 1, "R8 save done timing", 32'(done_cyc), 32'(last_hs + 1));
            chk(d_spwe == 1'b1 && d_spv == exp_sp, "R8 final stack pointer", d_spv, exp_sp);
        end
        chk(d_fnz == (!v.pop && n > 0), "R9 next fetch nonsequential", 32'(d_fnz), 32'(!v.pop && n > 0));
        chk(busy == 1'b0, "R12 idle after request", 32'(busy), 32'h0);
    endtask

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        checks = checks + 1;
        errors = errors + 1;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!busy && !done && !mem_req && !rf_we && !pc_load && !sp_we, "R13 reset state",
            {26'b0, busy, done, mem_req, rf_we, pc_load, sp_we}, 32'h0);
        @(posedge clk); #2;
        rst_n = 1'b1;

        for (int i = 0; i < 8; i++) run_op(VECS[i], 1'b0);

        // R10: empty list with no extra slot, both directions.
        run_op('{1'b0, 8'h00, 1'b0, 32'h0000_0800, 1'b0}, 1'b0);
        run_op('{1'b1, 8'h00, 1'b0, 32'h0000_0900, 1'b1}, 1'b0);

        // R12: start while busy is ignored.
        run_op('{1'b1, 8'hFF, 1'b1, 32'h0000_4000, 1'b1}, 1'b1);
        run_op('{1'b0, 8'b0101_0010, 1'b1, 32'h0000_5000, 1'b1}, 1'b1);

        // R13: reset during a stalled save aborts it.
        stall_mode = 1'b1;
        @(posedge clk); #2;
        start = 1'b1; pop_mode = 1'b0; reg_list = 8'hFF; extra_en = 1'b1; sp_in = 32'h0000_6000;
        @(posedge clk); #2;
        start = 1'b0;
        repeat (4) @(posedge clk);
        #2 rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk(!busy && !done && !mem_req && !rf_we && !pc_load && !sp_we, "R13 reset aborts request",
            {26'b0, busy, done, mem_req, rf_we, pc_load, sp_we}, 32'h0);
        @(posedge clk); #2;
        rst_n = 1'b1;
        run_op('{1'b1, 8'b0000_0110, 1'b1, 32'h0000_7000, 1'b0}, 1'b0);

        finish_run();
    end
endmodule